// File: doc/BRIEF.md
# Translation-Triggered Chained Prefetch Engine

This block sits in a memory controller. It takes read requests into an eight-slot transaction queue and sends them to DRAM. A request can carry a marker saying that it reads a leaf page-table entry. Such a request also carries the 6-bit line index that the pending access will use inside its 4 KiB page.

For a marked request the engine takes two queue slots at once. The first slot reads the entry. The second slot is a dependent read, and its address is not known yet. When the entry data comes back, it goes to the page walker as an ordinary read response. In the same step the engine takes the frame number from the entry and joins it with the carried line index to form a cache-line address. That fills in the dependent slot, which then competes for the DRAM port. The line it reads goes to the last-level cache as a fill marked as prefetch. If the entry is not present, the dependent slot is dropped.

The DRAM side is a fixed-latency port with no backpressure. Commands are tagged with the slot index, and responses return that tag. All outputs are registered. A walker response or fill appears one cycle after the DRAM response that causes it, and a command appears one cycle after its slot becomes eligible.

Top module: `xcp_chain_prefetch`

## Requirements
- R1: After reset, `req_ready` is high whatever `req_leaf` is, and `dram_cmd_valid`, `wlk_rsp_valid` and `fill_valid` are low.
- R2: An unmarked request produces exactly one DRAM command at its address. It then produces one walker response with its id and the DRAM data. Walker responses leave in the order the requests were accepted.
- R3: The queue holds 8 slots. An unmarked request is accepted only when at least one slot is free, and a marked request only when at least two are. A marked request holds one slot until its entry data returns and the other until its target read returns or is cancelled.
- R4: For a marked request, the entry data is also returned on the walker port with the request's id, exactly like an unmarked read.
- R5: The dependent target read is never commanded before the entry data has come back. It is eligible from the cycle after that data arrives.
- R6: The target address is entry bits [39:12], followed by the carried 6-bit line index, followed by six zero bits. The fill carries this address and the DRAM data read from it.
- R7: Every fill has `fill_pf` set to 1, so that the cache can tell it apart from demand data.
- R8: When bit 0 (present) of the returned entry is 0, there is no target read and no fill. Both slots of that request are free in the cycle its walker response is visible.
- R9: When several slots are eligible, the one allocated earliest is commanded first. Fills therefore leave in the order the marked requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle (depends on `req_leaf`) |
| req_leaf | input | 1 | Request reads a leaf translation entry |
| req_addr | input | 40 | Physical byte address of the read |
| req_lidx | input | 6 | Line index within the target page (marked requests) |
| req_id | input | 4 | Requester id returned with the walker response |
| dram_cmd_valid | output | 1 | DRAM read command |
| dram_cmd_addr | output | 40 | Address of the DRAM read |
| dram_cmd_tag | output | 3 | Slot index carried by the command |
| dram_rsp_valid | input | 1 | DRAM read data returned |
| dram_rsp_tag | input | 3 | Slot index of the returned data |
| dram_rsp_data | input | 64 | Returned data |
| wlk_rsp_valid | output | 1 | Read response to the walker/requester |
| wlk_rsp_id | output | 4 | Id of the answered request |
| wlk_rsp_data | output | 64 | Read data |
| fill_valid | output | 1 | Fill message to the last-level cache |
| fill_addr | output | 40 | Line address of the fill |
| fill_data | output | 64 | Line data of the fill |
| fill_pf | output | 1 | Prefetch tag of the fill |

## Verification
The bench tracks queue occupancy from the outside, based on accepts, walker responses and fills. Against that count it checks `req_ready` every cycle a request is offered. A design that admits a marked request with only one slot free, or that fails to free both slots when an entry is not present, shows up as a mismatch here. Every target-read command is checked to appear only after its entry's walker response, and to carry the address formed from the entry. A design that issues the dependent slot early, or splices the frame number or line index wrongly, is caught here. Fills are compared in order against expected addresses and data. Non-present entries must produce no fill, so a design that still sends the dependent read leaves an unexpected fill or command behind.

// File: rtl/xcp_pkg.sv
package xcp_pkg;
  typedef enum logic [1:0] {SL_FREE, SL_WAIT, SL_RDY, SL_BUSY} slot_st_e;
  typedef enum logic [1:0] {SK_NORM, SK_LEAF, SK_TGT} slot_kind_e;
  localparam int unsigned PTE_PRESENT_BIT = 0;
endpackage

// File: rtl/xcp_free_pick.sv
module xcp_free_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_vec,
  output logic [IW-1:0] first_idx,
  output logic [IW-1:0] second_idx,
  output logic [IW:0]   free_cnt
);
  logic got_first;
  logic got_second;

  always_comb begin
    first_idx  = '0;
    second_idx = '0;
    got_first  = 1'b0;
    got_second = 1'b0;
    free_cnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (free_vec[i]) begin
        free_cnt = free_cnt + 1'b1;
        if (!got_first) begin
          first_idx = IW'(i);
          got_first = 1'b1;
        end else if (!got_second) begin
          second_idx = IW'(i);
          got_second = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xcp_age_arb.sv
module xcp_age_arb #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic [IW-1:0] a_idx,
  input  logic          b_en,
  input  logic [IW-1:0] b_idx,
  input  logic [N-1:0]  ready_vec,
  output logic [N-1:0]  grant_vec,
  output logic          grant_valid,
  output logic [IW-1:0] grant_idx
);
  // older_q[i][j] set: slot i was allocated before slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];
  logic [N-1:0] blocked;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        older_d[i][j] = older_q[i][j];
        if (b_en && IW'(i) == b_idx)
          older_d[i][j] = 1'b0;
        else if (a_en && IW'(i) == a_idx)
          older_d[i][j] = b_en && (IW'(j) == b_idx);
        else if ((a_en && IW'(j) == a_idx) || (b_en && IW'(j) == b_idx))
          older_d[i][j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (a_en) begin
      for (int i = 0; i < N; i++) older_q[i] <= older_d[i];
    end
  end

  always_comb begin
    grant_vec   = '0;
    grant_idx   = '0;
    grant_valid = 1'b0;
    blocked     = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j != i && ready_vec[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
      grant_vec[i] = ready_vec[i] && !blocked[i];
    end
    for (int i = 0; i < N; i++) begin
      if (grant_vec[i]) begin
        grant_idx   = IW'(i);
        grant_valid = 1'b1;
      end
    end
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  p_grant_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready_vec) |-> grant_valid);
endmodule

// File: rtl/xcp_tgt_addr.sv
module xcp_tgt_addr #(
  parameter int PA_W     = 40,
  parameter int LIDX_W   = 6,
  parameter int LINE_OFF = 6,
  localparam int PAGE_W  = LIDX_W + LINE_OFF
) (
  input  logic [PA_W-1:PAGE_W] frame_bits,
  input  logic                 pres_bit,
  input  logic [LIDX_W-1:0]    lidx,
  output logic [PA_W-1:0]      tgt_addr,
  output logic                 present
);
  assign tgt_addr = {frame_bits, lidx, {LINE_OFF{1'b0}}};
  assign present  = pres_bit;
endmodule

// File: rtl/xcp_chain_prefetch.sv
module xcp_chain_prefetch
  import xcp_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PA_W     = 40,
  parameter int DATA_W   = 64,
  parameter int ID_W     = 4,
  parameter int LIDX_W   = 6,
  parameter int LINE_OFF = 6,
  localparam int TAG_W   = $clog2(DEPTH),
  localparam int PAGE_W  = LIDX_W + LINE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_leaf,
  input  logic [PA_W-1:0]   req_addr,
  input  logic [LIDX_W-1:0] req_lidx,
  input  logic [ID_W-1:0]   req_id,
  output logic              dram_cmd_valid,
  output logic [PA_W-1:0]   dram_cmd_addr,
  output logic [TAG_W-1:0]  dram_cmd_tag,
  input  logic              dram_rsp_valid,
  input  logic [TAG_W-1:0]  dram_rsp_tag,
  input  logic [DATA_W-1:0] dram_rsp_data,
  output logic              wlk_rsp_valid,
  output logic [ID_W-1:0]   wlk_rsp_id,
  output logic [DATA_W-1:0] wlk_rsp_data,
  output logic              fill_valid,
  output logic [PA_W-1:0]   fill_addr,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_pf
);
  typedef struct packed {
    slot_st_e          st;
    slot_kind_e        kind;
    logic [PA_W-1:0]   addr;
    logic [ID_W-1:0]   id;
    logic [LIDX_W-1:0] lidx;
    logic [TAG_W-1:0]  link;
  } slot_t;

  slot_t slot_q [DEPTH];
  slot_t slot_d [DEPTH];

  logic [DEPTH-1:0] free_vec, ready_vec, grant_vec;
  logic [TAG_W-1:0] free_a, free_b, grant_idx;
  logic [TAG_W:0]   free_cnt;
  logic             grant_valid, req_fire;

  logic [TAG_W-1:0] rsp_link;
  slot_kind_e       rsp_kind;
  logic [PA_W-1:0]  tgt_addr;
  logic             tgt_present;
  logic             rsp_leaf_pres, rsp_leaf_abs;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      free_vec[i]  = (slot_q[i].st == SL_FREE);
      ready_vec[i] = (slot_q[i].st == SL_RDY);
    end
  end

  xcp_free_pick #(.N(DEPTH), .IW(TAG_W)) u_free (
    .free_vec  (free_vec),
    .first_idx (free_a),
    .second_idx(free_b),
    .free_cnt  (free_cnt)
  );

  assign req_ready = req_leaf ? (free_cnt >= (TAG_W+1)'(2)) : (free_cnt != '0);
  assign req_fire  = req_valid && req_ready;

  xcp_age_arb #(.N(DEPTH), .IW(TAG_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_en       (req_fire),
    .a_idx      (free_a),
    .b_en       (req_fire && req_leaf),
    .b_idx      (free_b),
    .ready_vec  (ready_vec),
    .grant_vec  (grant_vec),
    .grant_valid(grant_valid),
    .grant_idx  (grant_idx)
  );

  assign rsp_kind = slot_q[dram_rsp_tag].kind;
  assign rsp_link = slot_q[dram_rsp_tag].link;

  xcp_tgt_addr #(.PA_W(PA_W), .LIDX_W(LIDX_W), .LINE_OFF(LINE_OFF)) u_form (
    .frame_bits(dram_rsp_data[PA_W-1:PAGE_W]),
    .pres_bit  (dram_rsp_data[PTE_PRESENT_BIT]),
    .lidx      (slot_q[rsp_link].lidx),
    .tgt_addr  (tgt_addr),
    .present   (tgt_present)
  );

  assign rsp_leaf_pres = dram_rsp_valid && rsp_kind == SK_LEAF && tgt_present;
  assign rsp_leaf_abs  = dram_rsp_valid && rsp_kind == SK_LEAF && !tgt_present;

  // slot next state: allocation, issue and completion touch disjoint slots
  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (req_fire) begin
      slot_d[free_a] = '{st: SL_RDY, kind: (req_leaf ? SK_LEAF : SK_NORM),
                         addr: req_addr, id: req_id, lidx: req_lidx, link: free_b};
      if (req_leaf)
        slot_d[free_b] = '{st: SL_WAIT, kind: SK_TGT, addr: '0, id: req_id,
                           lidx: req_lidx, link: free_a};
    end
    if (grant_valid) slot_d[grant_idx].st = SL_BUSY;
    if (dram_rsp_valid) begin
      slot_d[dram_rsp_tag].st = SL_FREE;
      if (rsp_leaf_pres) begin
        slot_d[rsp_link].st   = SL_RDY;
        slot_d[rsp_link].addr = tgt_addr;
      end else if (rsp_leaf_abs) begin
        slot_d[rsp_link].st = SL_FREE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        slot_q[i] <= '{st: SL_FREE, kind: SK_NORM, addr: '0, id: '0, lidx: '0, link: '0};
    end else begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  // output stage
  logic wrsp_v_d, fill_v_d;
  assign wrsp_v_d = dram_rsp_valid && rsp_kind != SK_TGT;
  assign fill_v_d = dram_rsp_valid && rsp_kind == SK_TGT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_cmd_valid <= 1'b0;
      wlk_rsp_valid  <= 1'b0;
      fill_valid     <= 1'b0;
      fill_pf        <= 1'b0;
    end else begin
      dram_cmd_valid <= grant_valid;
      wlk_rsp_valid  <= wrsp_v_d;
      fill_valid     <= fill_v_d;
      fill_pf        <= fill_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_cmd_addr <= '0;
      dram_cmd_tag  <= '0;
    end else if (grant_valid) begin
      dram_cmd_addr <= slot_q[grant_idx].addr;
      dram_cmd_tag  <= grant_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlk_rsp_id   <= '0;
      wlk_rsp_data <= '0;
    end else if (wrsp_v_d) begin
      wlk_rsp_id   <= slot_q[dram_rsp_tag].id;
      wlk_rsp_data <= dram_rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_addr <= '0;
      fill_data <= '0;
    end else if (fill_v_d) begin
      fill_addr <= slot_q[dram_rsp_tag].addr;
      fill_data <= dram_rsp_data;
    end
  end

  // checks beside the logic they guard
  p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (slot_q[free_a].st == SL_FREE) &&
                 (!req_leaf || (slot_q[free_b].st == SL_FREE && free_b != free_a)));
  p_rsp_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dram_rsp_valid |-> slot_q[dram_rsp_tag].st == SL_BUSY);
  p_grant_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> slot_q[grant_idx].st == SL_RDY);
  p_tgt_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_leaf_pres |=> slot_q[$past(rsp_link)].st == SL_RDY);
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_leaf_abs |=> slot_q[$past(rsp_link)].st == SL_FREE);
  p_fill_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> fill_addr[LINE_OFF-1:0] == '0);
  p_fill_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> fill_pf);
endmodule

// File: tb/test_xcp_chain_prefetch.sv
module test_xcp_chain_prefetch;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_leaf;
  logic [39:0] req_addr;
  logic [5:0]  req_lidx;
  logic [3:0]  req_id;
  logic        dram_cmd_valid;
  logic [39:0] dram_cmd_addr;
  logic [2:0]  dram_cmd_tag;
  logic        dram_rsp_valid;
  logic [2:0]  dram_rsp_tag;
  logic [63:0] dram_rsp_data;
  logic        wlk_rsp_valid;
  logic [3:0]  wlk_rsp_id;
  logic [63:0] wlk_rsp_data;
  logic        fill_valid;
  logic [39:0] fill_addr;
  logic [63:0] fill_data;
  logic        fill_pf;

  always #2 clk = ~clk;

  xcp_chain_prefetch i_xcp_chain_prefetch (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_leaf(req_leaf),
    .req_addr(req_addr), .req_lidx(req_lidx), .req_id(req_id),
    .dram_cmd_valid(dram_cmd_valid), .dram_cmd_addr(dram_cmd_addr), .dram_cmd_tag(dram_cmd_tag),
    .dram_rsp_valid(dram_rsp_valid), .dram_rsp_tag(dram_rsp_tag), .dram_rsp_data(dram_rsp_data),
    .wlk_rsp_valid(wlk_rsp_valid), .wlk_rsp_id(wlk_rsp_id), .wlk_rsp_data(wlk_rsp_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data), .fill_pf(fill_pf)
  );

  typedef struct {
    logic [3:0]  id;
    logic [63:0] data;
    bit          leaf;
    bit          pres;
  } wexp_t;
  typedef struct {
    logic [39:0] addr;
    logic [63:0] data;
  } fexp_t;

  wexp_t       exp_w[$];
  fexp_t       exp_f[$];
  logic [39:0] exp_t[$];
  int checks = 0, errors = 0, occ = 0, pend = 0, cyc = 0;
  int pres_leaf_seen = 0, tgt_cmds = 0, fills_seen = 0;

  logic        pv [LAT];
  logic [2:0]  pt [LAT];
  logic [39:0] pa [LAT];

  // memory image: region 0x8... holds lines, entries point there, bit0 = a[3]
  function automatic logic [63:0] mem_f(input logic [39:0] a);
    return {24'h0, 4'h8, a[27:4], 11'h0, a[3]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // monitor, scoreboard and DRAM model, all at the falling edge
  always @(negedge clk) begin
    wexp_t       we;
    fexp_t       fe;
    logic [39:0] te;
    cyc++;
    if (cyc > 40000) begin
      chk(1'b0, "WD", "watchdog expired", 64'(cyc), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      occ += pend;
      if (wlk_rsp_valid) begin
        if (exp_w.size() == 0) chk(1'b0, "R2", "unexpected walker rsp", 64'(wlk_rsp_id), 64'd0);
        else begin
          we = exp_w.pop_front();
          chk(wlk_rsp_id == we.id, we.leaf ? "R4" : "R2", "walker id", 64'(wlk_rsp_id), 64'(we.id));
          chk(wlk_rsp_data == we.data, we.leaf ? "R4" : "R2", "walker data", wlk_rsp_data, we.data);
          if (we.leaf && we.pres) begin pres_leaf_seen++; occ -= 1; end
          else if (we.leaf) occ -= 2;   // R8: both slots released together
          else occ -= 1;
        end
      end
      if (fill_valid) begin
        fills_seen++;
        occ -= 1;
        if (exp_f.size() == 0) chk(1'b0, "R8", "unexpected fill", 64'(fill_addr), 64'd0);
        else begin
          fe = exp_f.pop_front();
          chk(fill_addr == fe.addr, "R9", "fill order/address", 64'(fill_addr), 64'(fe.addr));
          chk(fill_data == fe.data, "R6", "fill data", fill_data, fe.data);
          chk(fill_pf == 1'b1, "R7", "fill prefetch tag", 64'(fill_pf), 64'd1);
        end
      end
      if (dram_cmd_valid && dram_cmd_addr[39:36] == 4'h8) begin
        chk(tgt_cmds < pres_leaf_seen, "R5", "target read before entry data",
            64'(tgt_cmds), 64'(pres_leaf_seen));
        if (exp_t.size() == 0) chk(1'b0, "R8", "unexpected target read", 64'(dram_cmd_addr), 64'd0);
        else begin
          te = exp_t.pop_front();
          chk(dram_cmd_addr == te, "R6", "target address", 64'(dram_cmd_addr), 64'(te));
        end
        tgt_cmds++;
      end
      if (req_valid)
        chk(req_ready == (req_leaf ? (occ <= 6) : (occ <= 7)), "R3", "admission",
            64'(req_ready), 64'(occ));
      pend = (req_valid && req_ready) ? (req_leaf ? 2 : 1) : 0;
    end
    dram_rsp_valid = pv[LAT-1] && rst_n;
    dram_rsp_tag   = pt[LAT-1];
    dram_rsp_data  = mem_f(pa[LAT-1]);
    for (int k = LAT-1; k > 0; k--) begin
      pv[k] = pv[k-1]; pt[k] = pt[k-1]; pa[k] = pa[k-1];
    end
    pv[0] = dram_cmd_valid && rst_n;
    pt[0] = dram_cmd_tag;
    pa[0] = dram_cmd_addr;
  end

  // called and returning at posedge+1
  task automatic send(input bit leaf, input logic [39:0] a, input logic [5:0] lx,
                      input logic [3:0] id);
    bit          done;
    logic [63:0] e;
    logic [39:0] t;
    done = 1'b0;
    req_valid = 1'b1; req_leaf = leaf; req_addr = a; req_lidx = lx; req_id = id;
    while (!done) begin
      #2;
      if (req_ready) begin
        done = 1'b1;
        e = mem_f(a);
        exp_w.push_back('{id: id, data: e, leaf: leaf, pres: a[3]});
        if (leaf && a[3]) begin
          t = {e[39:12], lx, 6'b0};
          exp_f.push_back('{addr: t, data: mem_f(t)});
          exp_t.push_back(t);
        end
      end
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int k = 0; k < LAT; k++) begin pv[k] = 1'b0; pt[k] = '0; pa[k] = '0; end
    dram_rsp_valid = 1'b0; dram_rsp_tag = '0; dram_rsp_data = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_leaf = 1'b1;
    req_addr = '0; req_lidx = '0; req_id = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1", "ready in reset (marked)", 64'(req_ready), 64'd1);
    chk(dram_cmd_valid == 1'b0 && wlk_rsp_valid == 1'b0 && fill_valid == 1'b0,
        "R1", "outputs idle in reset", 64'({dram_cmd_valid, wlk_rsp_valid, fill_valid}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: unmarked reads, sparse
    send(1'b0, 40'h10_0000_1000, 6'd0, 4'h1);
    idle(12);
    send(1'b0, 40'h10_0345_6788, 6'd0, 4'h2);
    send(1'b0, 40'h12_0000_0040, 6'd0, 4'h3);
    idle(12);

    // R4/R6: marked, present, line index at both ends; R8: not present
    send(1'b1, 40'h11_2345_6788, 6'd0,  4'h4);
    idle(14);
    send(1'b1, 40'h11_ABCD_E008, 6'd63, 4'h5);
    send(1'b1, 40'h11_0F0F_0F00, 6'd21, 4'h6);
    idle(24);
    chk(fills_seen == 2, "R8", "no fill for absent entry", 64'(fills_seen), 64'd2);
    chk(occ == 0, "R8", "slots released after absent entry", 64'(occ), 64'd0);
    req_leaf = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R3", "two slots free again", 64'(req_ready), 64'd1);
    @(posedge clk); #1;

    // R3/R5/R9: back-to-back mixed burst to press on capacity and ordering
    for (int i = 0; i < 48; i++) begin
      send((i % 3) != 0,
           {4'h1, 20'(i * 37), 12'(i), 1'((i % 5) != 0), 3'b000},
           6'((i * 7) % 64), 4'(i));
    end

    while (exp_w.size() != 0 || exp_f.size() != 0) idle(1);
    idle(10);
    chk(exp_t.size() == 0, "R5", "all target reads seen", 64'(exp_t.size()), 64'd0);
    chk(occ == 0, "R3", "queue drained", 64'(occ), 64'd0);
    chk(tgt_cmds == pres_leaf_seen, "R8", "target reads match present entries",
        64'(tgt_cmds), 64'(pres_leaf_seen));
    req_leaf = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R3", "ready after drain", 64'(req_ready), 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule